// File: doc/BRIEF.md
# Configurable Multi-Port General-Purpose I/O Bank

This block is a bank of identical 8-bit general-purpose I/O ports. There are three by default, which gives 24 pins. Each pin takes its function from four control bits, one at the same bit index in each of four per-port registers:

- a data register;
- a direction register;
- a low function-select register;
- a high function-select register.

The data bit has two jobs. It is the drive level in output mode, and it is a polarity selector in the interrupt modes. A direction bit of 0 selects output and a direction bit of 1 selects input, which is the reverse of the usual convention.

Pad inputs pass through a two-flop synchronizer. The synchronized level is what a read of the data register returns, and it is also what the interrupt logic watches. Each pin can be an edge-triggered source, which latches a sticky flag that software clears by writing 1. It can instead be a level-sensitive source, which asserts while the pin matches the chosen level. Each port drives one interrupt request. A CPU reaches the bank through a simple synchronous bus: a single-cycle write strobe and a combinational read.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every direction register reads 0xFF, and the data, both function-select and status registers read 0x00. Every pad output enable is 0 and every port interrupt is 0.
- R2: With {func_hi, func_lo, dir} = 000, the pad output enable is 1 and the pad output level equals the data register bit.
- R3: With func_hi = 0, func_lo = 0 and dir = 1, the pin is an input: the output enable is 0 and the output is 0, whatever the data bit holds.
- R4: Register offset 0 (data) reads the synchronized pad level, not the value last written. A pad change is visible there at most 2 clock edges after it is sampled.
- R5: With {func_hi, func_lo, dir} = 100, the pin is an edge interrupt source. Data bit 1 selects a rising edge and data bit 0 selects a falling edge. A matching edge sets that pin's bit in the status register (offset 4) within 3 clock edges.
- R6: With {func_hi, func_lo, dir} = 101, the pin is a level interrupt source. It requests an interrupt while the synchronized pin equals the data bit, and it latches nothing.
- R7: Writing the status register clears exactly the flags written with 1. Bits written with 0 keep their value, and a flag falls only through such a write.
- R8: Any code with func_lo = 1 makes the pin a high-impedance input that never sets a flag and never requests an interrupt.
- R9: Each port's irq output is the OR of that port's status flags and its active level conditions. Ports do not affect one another.
- R10: bus_addr[4:3] selects the port (0 to 2) and bus_addr[2:0] selects the register: 0 data, 1 direction, 2 func_lo, 3 func_hi, 4 status. Other offsets and port 3 read 0x00, and writes to them change nothing.
- R11: Pad output enables and pad output levels change only in the cycle after a bus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Single-cycle register write strobe |
| bus_addr | input | 5 | Port select [4:3] and register offset [2:0] |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| pad_in | input | 24 | Pad input levels, port p at bits [8p+7:8p] |
| pad_out | output | 24 | Pad drive levels |
| pad_oe | output | 24 | Pad output enables |
| irq | output | 3 | One interrupt request per port |

## Verification
A wrong mode decode shows up on pad_oe and pad_out in the cycle right after the configuring write. A broken synchronizer or readback path shows up as a wrong data-register read within two cycles of a pad change. A stuck or missed edge flag shows up on both irq and the status register within three cycles of the edge. A flag that survives a 1-write, or that is lost through a 0-write, shows up on the very next status read. Level conditions are checked against the pin every step, so a latched level term is caught as soon as the pin leaves the active level.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int REG_IDX_W = 3;

  typedef enum logic [REG_IDX_W-1:0] {
    RG_DATA = 3'd0,
    RG_DIR  = 3'd1,
    RG_FLO  = 3'd2,
    RG_FHI  = 3'd3,
    RG_FLAG = 3'd4
  } reg_idx_e;

  typedef enum logic [1:0] {
    PM_DRIVE,
    PM_FLOAT,
    PM_EDGE,
    PM_LEVEL
  } pin_mode_e;

  // Maps a pin's control bits to its function. The data bit only picks
  // the level or polarity, so it does not take part here.
  function automatic pin_mode_e decode_mode(logic fhi, logic flo, logic dir);
    pin_mode_e m;
    case ({fhi, flo, dir})
      3'b000:  m = PM_DRIVE;
      3'b100:  m = PM_EDGE;
      3'b101:  m = PM_LEVEL;
      default: m = PM_FLOAT;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/gpio_bank_rst_sync.sv
module gpio_bank_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;

endmodule

// File: rtl/gpio_bank_port.sv
module gpio_bank_port
  import gpio_bank_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [REG_IDX_W-1:0] reg_idx,
  input  logic [PW-1:0]        wdata,
  input  logic [PW-1:0]        pin_in,
  output logic [PW-1:0]        rd_data,
  output logic [PW-1:0]        pad_out,
  output logic [PW-1:0]        pad_oe,
  output logic [PW-1:0]        flags,
  output logic                 irq
);

  logic [PW-1:0] data_q, dir_q, flo_q, fhi_q, flag_q, prev_q;
  logic [PW-1:0] flag_d;
  logic          data_en, dir_en, flo_en, fhi_en, flag_en;
  logic [PW-1:0] flag_clr;
  logic [PW-1:0] pin_s;
  logic [PW-1:0] edge_hit, level_hit, oe_w;

  gpio_bank_sync #(.W(PW)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pin_s)
  );

  // Write decode and clock enables
  always_comb begin
    data_en  = wr_en && (reg_idx == RG_DATA);
    dir_en   = wr_en && (reg_idx == RG_DIR);
    flo_en   = wr_en && (reg_idx == RG_FLO);
    fhi_en   = wr_en && (reg_idx == RG_FHI);
    flag_clr = (wr_en && (reg_idx == RG_FLAG)) ? wdata : '0;
    // A new edge wins over a clear in the same cycle
    flag_d   = (flag_q & ~flag_clr) | edge_hit;
    flag_en  = (|flag_clr) || (|edge_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '1;
      flo_q  <= '0;
      fhi_q  <= '0;
      flag_q <= '0;
      prev_q <= '0;
    end else begin
      if (data_en) data_q <= wdata;
      if (dir_en)  dir_q  <= wdata;
      if (flo_en)  flo_q  <= wdata;
      if (fhi_en)  fhi_q  <= wdata;
      if (flag_en) flag_q <= flag_d;
      prev_q <= pin_s;
    end
  end

  // Per-pin mode decode and interrupt conditions
  for (genvar i = 0; i < PW; i++) begin : g_pin
    pin_mode_e mode;
    logic      rise, fall;
    always_comb begin
      mode = decode_mode(fhi_q[i], flo_q[i], dir_q[i]);
      rise = pin_s[i] & ~prev_q[i];
      fall = ~pin_s[i] & prev_q[i];
    end
    assign oe_w[i]      = (mode == PM_DRIVE);
    assign edge_hit[i]  = (mode == PM_EDGE) && (data_q[i] ? rise : fall);
    assign level_hit[i] = (mode == PM_LEVEL) && (pin_s[i] == data_q[i]);
  end

  assign pad_oe  = oe_w;
  assign pad_out = oe_w & data_q;
  assign flags   = flag_q;
  assign irq     = (|flag_q) | (|level_hit);

  // Register readback; the data offset returns the pin level
  always_comb begin
    case (reg_idx)
      RG_DATA: rd_data = pin_s;
      RG_DIR:  rd_data = dir_q;
      RG_FLO:  rd_data = flo_q;
      RG_FHI:  rd_data = fhi_q;
      RG_FLAG: rd_data = flag_q;
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPORTS = 3,
  parameter int PW     = 8,
  localparam int PSEL_W = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int AW     = PSEL_W + REG_IDX_W,
  localparam int NPINS  = NPORTS * PW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [PW-1:0]    bus_wdata,
  output logic [PW-1:0]    bus_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPORTS-1:0] irq
);

  logic                 rst_n_int;
  logic [PSEL_W-1:0]    psel;
  logic [REG_IDX_W-1:0] ridx;
  logic [PW-1:0]        rd_all [NPORTS];
  logic [NPINS-1:0]     flag_all;

  gpio_bank_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign psel = bus_addr[AW-1:REG_IDX_W];
  assign ridx = bus_addr[REG_IDX_W-1:0];

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic hit;
    assign hit = bus_wr && (psel == PSEL_W'(p));
    gpio_bank_port #(.PW(PW)) i_port (
      .clk     (clk),
      .rst_n   (rst_n_int),
      .wr_en   (hit),
      .reg_idx (ridx),
      .wdata   (bus_wdata),
      .pin_in  (pad_in[p*PW +: PW]),
      .rd_data (rd_all[p]),
      .pad_out (pad_out[p*PW +: PW]),
      .pad_oe  (pad_oe[p*PW +: PW]),
      .flags   (flag_all[p*PW +: PW]),
      .irq     (irq[p])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int p = 0; p < NPORTS; p++) begin
      if (psel == PSEL_W'(p)) bus_rdata = rd_all[p];
    end
  end

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NPORTS = 3,
  parameter int PW     = 8,
  parameter int AW     = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_wr,
  input logic [AW-1:0]        bus_addr,
  input logic [PW-1:0]        bus_wdata,
  input logic [NPORTS*PW-1:0] pad_oe,
  input logic [NPORTS*PW-1:0] pad_out,
  input logic [NPORTS-1:0]    irq,
  input logic [NPORTS*PW-1:0] flags
);

  logic wrote_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wrote_q <= 1'b0;
    else if (bus_wr) wrote_q <= 1'b1;
  end

  // R1: with no write since reset, nothing drives and nothing interrupts
  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wrote_q |-> (pad_oe == '0 && irq == '0));

  // R11: a newly enabled driver follows a write
  assert_oe_rise_after_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & ~$past(pad_oe)) != '0) |-> $past(bus_wr));

  // R11: a drive level change follows a write
  assert_out_change_after_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pad_out) |-> $past(bus_wr));

  // R7: a flag falls only through a 1 written to its status bit
  for (genvar g = 0; g < NPORTS; g++) begin : g_cp
    for (genvar b = 0; b < PW; b++) begin : g_cb
      assert_flag_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags[g*PW+b]) |->
          $past(bus_wr && (bus_addr == AW'((g << 3) | 4)) && bus_wdata[b]));
    end
  end

endmodule

bind gpio_bank gpio_bank_chk #(.NPORTS(NPORTS), .PW(PW), .AW(AW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pad_oe    (pad_oe),
  .pad_out   (pad_out),
  .irq       (irq),
  .flags     (flag_all)
);

// File: tb/test_gpio_bank.sv
module test_gpio_bank;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [4:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [23:0] pad_in;
  logic [23:0] pad_out;
  logic [23:0] pad_oe;
  logic [2:0]  irq;

  gpio_bank i_gpio_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  logic [7:0] m_data [3];
  logic [7:0] m_dir  [3];
  logic [7:0] m_flo  [3];
  logic [7:0] m_fhi  [3];
  logic [7:0] m_flag [3];

  function automatic logic [7:0] exp_oe(int p);
    return ~m_fhi[p] & ~m_flo[p] & ~m_dir[p];
  endfunction

  function automatic logic [7:0] exp_edge_mode(int p);
    return m_fhi[p] & ~m_flo[p] & ~m_dir[p];
  endfunction

  function automatic logic exp_irq(int p);
    logic [7:0] lvl_mode, pins;
    lvl_mode = m_fhi[p] & ~m_flo[p] & m_dir[p];
    pins     = pad_in[p*8 +: 8];
    return (|m_flag[p]) | (|(lvl_mode & ~(pins ^ m_data[p])));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(logic [4:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_wr   = 1'b0;
    bus_addr = a;
    #2;
    v = bus_rdata;
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] v);
    int p, r;
    p = int'(a[4:3]);
    r = int'(a[2:0]);
    @(negedge clk);
    bus_wr    = 1'b1;
    bus_addr  = a;
    bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0;
    if (p < 3) begin
      case (r)
        0: m_data[p] = v;
        1: m_dir[p]  = v;
        2: m_flo[p]  = v;
        3: m_fhi[p]  = v;
        4: m_flag[p] = m_flag[p] & ~v;
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic set_pins(logic [23:0] nv);
    for (int p = 0; p < 3; p++) begin
      logic [7:0] o, n, em;
      o  = pad_in[p*8 +: 8];
      n  = nv[p*8 +: 8];
      em = exp_edge_mode(p);
      m_flag[p] = m_flag[p] | (em & ((m_data[p] & ~o & n) | (~m_data[p] & o & ~n)));
    end
    @(negedge clk);
    pad_in = nv;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_all(string tag);
    logic [7:0] v;
    for (int p = 0; p < 3; p++) begin
      chk({tag, " R2/R3/R8 oe"}, pad_oe[p*8 +: 8], exp_oe(p));
      chk({tag, " R2 out"}, pad_out[p*8 +: 8], exp_oe(p) & m_data[p]);
      chk({tag, " R9 irq"}, irq[p], exp_irq(p));
      rd(5'(p*8 + 0), v);
      chk({tag, " R4 data readback"}, v, pad_in[p*8 +: 8]);
      rd(5'(p*8 + 4), v);
      chk({tag, " R5/R7 status"}, v, m_flag[p]);
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd2024));
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; pad_in = '0;
    for (int p = 0; p < 3; p++) begin
      m_data[p] = 8'h00; m_dir[p] = 8'hFF; m_flo[p] = 8'h00;
      m_fhi[p] = 8'h00; m_flag[p] = 8'h00;
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset values
    for (int p = 0; p < 3; p++) begin
      rd(5'(p*8 + 1), v); chk("R1 dir reset", v, 8'hFF);
      rd(5'(p*8 + 2), v); chk("R1 func_lo reset", v, 8'h00);
      rd(5'(p*8 + 3), v); chk("R1 func_hi reset", v, 8'h00);
    end
    chk("R1 oe reset", pad_oe, 24'h0);
    chk("R1 irq reset", irq, 3'b000);
    check_all("reset");

    // R3: input mode ignores data bit
    wr(5'd0, 8'hFF);
    check_all("R3 input");
    // R2 / R4: output mode, readback shows the pin
    wr(5'd1, 8'h00);
    wr(5'd0, 8'hA5);
    chk("R2 drive level", pad_out[7:0], 8'hA5);
    check_all("R2 out");
    set_pins(24'h00003C);
    rd(5'd0, v); chk("R4 readback not written", v, 8'h3C);

    // R8: func_lo set -> floating input, no irq
    wr(5'd10, 8'hFF); wr(5'd11, 8'hFF); wr(5'd9, 8'h00);
    set_pins(24'h00FF3C);
    check_all("R8 undefined");
    chk("R8 no irq", irq[1], 1'b0);
    set_pins(24'h00003C);
    check_all("R8 undefined fall");

    // R5 / R7: edges on port 2, low nibble rising, high nibble falling
    wr(5'd19, 8'hFF); wr(5'd17, 8'h00); wr(5'd16, 8'h0F);
    set_pins(24'hFF003C);
    rd(5'd20, v); chk("R5 rising flags", v, 8'h0F);
    chk("R9 edge irq", irq[2], 1'b1);
    wr(5'd20, 8'h00);
    rd(5'd20, v); chk("R7 zero write keeps", v, 8'h0F);
    wr(5'd20, 8'h03);
    rd(5'd20, v); chk("R7 partial clear", v, 8'h0C);
    set_pins(24'h00003C);
    rd(5'd20, v); chk("R5 falling flags", v, 8'hFC);
    check_all("R5 edges");
    wr(5'd20, 8'hFF);
    chk("R7 all cleared irq", irq[2], 1'b0);

    // R6: level mode on port 1 bit 0, active high
    wr(5'd10, 8'h00); wr(5'd11, 8'h01); wr(5'd9, 8'hFF); wr(5'd8, 8'h01);
    set_pins(24'h00013C);
    chk("R6 level active", irq[1], 1'b1);
    set_pins(24'h00003C);
    chk("R6 level inactive", irq[1], 1'b0);
    check_all("R6 level");

    // R10: unused offsets and port 3 are inert
    wr(5'd5, 8'hFF); wr(5'd25, 8'h00); wr(5'd24, 8'hFF);
    rd(5'd5, v);  chk("R10 unused offset reads 0", v, 8'h00);
    rd(5'd25, v); chk("R10 port 3 reads 0", v, 8'h00);
    check_all("R10 inert");

    // Random mix
    for (int it = 0; it < 400; it++) begin
      int sel;
      sel = int'($urandom % 5);
      case (sel)
        0, 1: wr(5'(($urandom % 3) * 8 + ($urandom % 4)), 8'($urandom));
        2: set_pins(pad_in ^ 24'($urandom));
        3: wr(5'(($urandom % 3) * 8 + 4), 8'($urandom));
        default: wr(5'(($urandom % 2) ? (24 + ($urandom % 8)) : (($urandom % 3) * 8 + 5 + ($urandom % 3))),
                    8'($urandom));
      endcase
      check_all("random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule